// File: doc/BRIEF.md
# Sticky Status Interrupt Controller

This block gathers event flags from a serial bus master into one status word and raises a single interrupt line. A few flags record events and stay set until software clears them through a dedicated write-one-to-clear register. The rest are not stored at all: they mirror whatever level the bus logic currently drives, such as FIFO fill conditions, bus activity and transmitter emptiness.

An enable register masks the status word. The controller reports the highest-numbered flag that is both set and enabled. Error and completion events sit above the data-request flags, so a service routine that handles the reported index first deals with failures and completions before it refills a transmitter. A small synchronous register port with four word addresses gives access to status, enable, clear and the pending index.

The interrupt line comes from a two-state machine. In `IRQ_IDLE` the line is low. The transition `raise` moves to `IRQ_ASSERT` on a clock edge where the masked status is non-zero. In `IRQ_ASSERT` the line is high. The transition `drop` returns to `IRQ_IDLE` on an edge where the masked status is zero.

Top module: `sisc_irq_ctrl`

## Requirements
- R1: Status bits 6, 7, 8, 10 and 11 are sticky. An `ev_in` bit that is high at a rising clock edge sets the matching flag, and the flag then stays set after the input falls, until it is cleared.
- R2: A write to address 2 clears each sticky flag whose `reg_wdata` bit is 1. Bits written as 0, and bits at non-sticky positions, change nothing.
- R3: If a sticky event and a clear of the same bit occur in the same cycle, the flag is set after that edge.
- R4: Status bits 0–5, 9 and 12–14 hold no state. In the same cycle they equal the matching `ev_in` bit, and clear writes do not affect them.
- R5: Address 1 is the enable register and can be read and written. Only bits 0–4, 6–8, 10–12 and 14 (mask 0x5DDF) can be written. Every other bit reads 0.
- R6: `pend_idx` is the position of the most significant 1 in (status AND enable), and `pend_none` is 0 while that bit exists. When no such bit exists, `pend_none` is 1 and `pend_idx` is 0. A read of address 3 returns `pend_none` at bit 4 and `pend_idx` at bits 3:0.
- R7: `irq` is registered. After each rising edge it equals the OR-reduction of (status AND enable) as it stood just before that edge.
- R8: After reset, every sticky flag and the enable register are 0, and `irq` is low.
- R9: A read of address 0 returns the status word in bits 14:0. A read of address 2 returns 0. Writes to addresses 0 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in | input | 15 | Event pulses (sticky positions) and live levels (other positions) |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address: 0 status, 1 enable, 2 clear, 3 pending |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt, registered |
| pend_idx | output | 4 | Index of the highest pending enabled flag |
| pend_none | output | 1 | High when no enabled flag is pending |

## Verification
The bench targets four corner cases:

- **Event and clear in the same cycle.** A design that lets the clear win drops an event that arrives while software clears the previous one.
- **Live positions ignore clear writes and hold nothing.** A design that stored them would report a FIFO or busy condition after it has gone away.
- **Priority between flags.** Arbitration-lost and completion flags must outrank transmit-empty. An encoder that picks the lowest bit would send the handler to refill data while an error is outstanding.
- **One-cycle lag of the interrupt.** The line must trail the masked status by exactly one cycle. A combinational line, or a second register stage, shows up as a mismatch on the cycle where the masked status changes.

// File: rtl/sisc_pkg.sv
package sisc_pkg;

    localparam int STAT_W = 15;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    // sticky event positions: 6,7,8,10,11
    localparam logic [STAT_W-1:0] STICKY_MASK = 15'h0DC0;
    // writable enable positions: 0-4,6-8,10-12,14
    localparam logic [STAT_W-1:0] ENABLE_MASK = 15'h5DDF;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_CLEAR   = 2'd2,
        SEL_PENDING = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ASSERT = 1'b1
    } irq_state_e;

endpackage

// File: rtl/sisc_sticky_bank.sv
module sisc_sticky_bank
    import sisc_pkg::*;
#(
    parameter int W = STAT_W,
    parameter logic [W-1:0] KEEP_MASK = STICKY_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_in,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] view
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (KEEP_MASK[b]) begin : g_keep
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (ev_in[b]) begin
                    flag_q <= 1'b1;
                end else if (clr_vec[b]) begin
                    flag_q <= 1'b0;
                end
            end

            assign view[b] = flag_q;

            a_r3_event_beats_clear : assert property (
                @(posedge clk) disable iff (!rst_n)
                ev_in[b] |=> view[b]
            ) else $error("event lost on sticky bit %0d", b);

            a_r1_hold_until_clear : assert property (
                @(posedge clk) disable iff (!rst_n)
                (view[b] && !clr_vec[b]) |=> view[b]
            ) else $error("sticky bit %0d dropped without clear", b);
        end else begin : g_live
            assign view[b] = ev_in[b];
        end
    end

endmodule

// File: rtl/sisc_prio_enc.sv
module sisc_prio_enc #(
    parameter int W     = 15,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             none
);

    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx  = IDX_W'(i);
                none = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sisc_regport.sv
module sisc_regport
    import sisc_pkg::*;
#(
    parameter int W      = STAT_W,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int IDX_W  = $clog2(W),
    parameter logic [W-1:0] EN_MASK  = ENABLE_MASK,
    parameter logic [W-1:0] CLR_MASK = STICKY_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [W-1:0]     view,
    input  logic [IDX_W-1:0] pend_idx,
    input  logic             pend_none,
    output logic [W-1:0]     en_q,
    output logic [W-1:0]     clr_vec,
    output logic [DW-1:0]    rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr && sel == SEL_ENABLE) begin
            en_q <= wdata[W-1:0] & EN_MASK;
        end
    end

    always_comb begin
        clr_vec = '0;
        if (wr && sel == SEL_CLEAR) begin
            clr_vec = wdata[W-1:0] & CLR_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STATUS:  rdata[W-1:0]       = view;
            SEL_ENABLE:  rdata[W-1:0]       = en_q;
            SEL_CLEAR:   rdata              = '0;
            SEL_PENDING: rdata[IDX_W:0]     = {pend_none, pend_idx};
            default:     rdata              = '0;
        endcase
    end

    a_r5_enable_masked : assert property (
        @(posedge clk) disable iff (!rst_n)
        (en_q & ~EN_MASK) == '0
    ) else $error("unimplemented enable bit set");

    a_r5_enable_stable : assert property (
        @(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_ENABLE) |=> $stable(en_q)
    ) else $error("enable changed without write");

endmodule

// File: rtl/sisc_irq_ctrl.sv
module sisc_irq_ctrl
    import sisc_pkg::*;
#(
    parameter int W     = STAT_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     ev_in,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    output logic [IDX_W-1:0] pend_idx,
    output logic             pend_none
);

    logic [W-1:0] view;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] masked;

    sisc_sticky_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_in   (ev_in),
        .clr_vec (clr_vec),
        .view    (view)
    );

    assign masked = view & en_q;

    sisc_prio_enc #(.W(W), .IDX_W(IDX_W)) u_enc (
        .vec  (masked),
        .idx  (pend_idx),
        .none (pend_none)
    );

    sisc_regport #(.W(W), .DW(DW), .AW(AW), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .view      (view),
        .pend_idx  (pend_idx),
        .pend_none (pend_none),
        .en_q      (en_q),
        .clr_vec   (clr_vec),
        .rdata     (reg_rdata)
    );

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (!pend_none) state_d = IRQ_ASSERT;
            IRQ_ASSERT: if (pend_none)  state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERT);
    end

    a_r7_irq_raise : assert property (
        @(posedge clk) disable iff (!rst_n)
        (masked != '0) |=> irq
    ) else $error("irq did not follow pending flag");

    a_r7_irq_drop : assert property (
        @(posedge clk) disable iff (!rst_n)
        (masked == '0) |=> !irq
    ) else $error("irq high with nothing pending");

    a_r6_index_is_top : assert property (
        @(posedge clk) disable iff (!rst_n)
        !pend_none |-> ((masked >> pend_idx) == W'(1))
    ) else $error("pending index is not the top set bit");

    a_r6_none_means_empty : assert property (
        @(posedge clk) disable iff (!rst_n)
        pend_none |-> (masked == '0 && pend_idx == '0)
    ) else $error("no-pending flag wrong");

endmodule

// File: tb/sisc_irq_ctrl_test.sv
module sisc_irq_ctrl_test;

    localparam logic [14:0] STK = 15'h0DC0;
    localparam logic [14:0] ENM = 15'h5DDF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ev_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [3:0]  pend_idx;
    logic        pend_none;

    int checks = 0;
    int failures = 0;

    logic [14:0] sticky_m = '0;
    logic [14:0] en_m = '0;
    logic        irq_m = 1'b0;

    always #10 clk = ~clk;

    sisc_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_in     (ev_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .pend_idx  (pend_idx),
        .pend_none (pend_none)
    );

    function automatic logic [14:0] exp_view(logic [14:0] ev);
        return (sticky_m & STK) | (ev & ~STK);
    endfunction

    function automatic logic [4:0] exp_pend(logic [14:0] m);
        logic [4:0] r = 5'h10;
        for (int i = 0; i < 15; i++) if (m[i]) r = {1'b0, 4'(i)};
        return r;
    endfunction

    function automatic logic [15:0] exp_read(logic [1:0] a, logic [14:0] ev);
        logic [14:0] v = exp_view(ev);
        case (a)
            2'd0: return {1'b0, v};
            2'd1: return {1'b0, en_m};
            2'd2: return 16'h0;
            default: return {11'h0, exp_pend(v & en_m)};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [14:0] ev, logic wr, logic [1:0] a,
                       logic [15:0] wd, string tag);
        logic [14:0] v;
        @(negedge clk);
        ev_in = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        v = exp_view(ev);
        chk(tag, reg_rdata, exp_read(a, ev));
        chk("R6 pending", {pend_none, pend_idx}, exp_pend(v & en_m));
        chk("R7 irq", irq, irq_m);
        @(posedge clk);
        irq_m = |(v & en_m);
        if (wr && a == 2'd2) sticky_m = sticky_m & ~(wd[14:0] & STK);
        sticky_m = sticky_m | (ev & STK);
        if (wr && a == 2'd1) en_m = wd[14:0] & ENM;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd7741;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        cyc(15'h0, 1'b0, 2'd0, 16'h0, "R8 status after reset");
        cyc(15'h0, 1'b0, 2'd1, 16'h0, "R8 enable after reset");
        chk("R8 irq after reset", irq, 1'b0);
        // R4 live levels, no storage
        cyc(15'h3204, 1'b0, 2'd0, 16'h0, "R4 live level");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R4 live no storage");
        // R1 sticky hold
        cyc(15'h0080, 1'b0, 2'd0, 16'h0, "R1 pulse");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R1 held");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R1 held2");
        chk("R1 sticky bit 7", reg_rdata, 16'h0080);
        // R2 clear with zeros and with live positions
        cyc(15'h0000, 1'b1, 2'd2, 16'h0000, "R2 clear zero");
        cyc(15'h3204, 1'b1, 2'd2, 16'h3204, "R2 clear live pos");
        cyc(15'h3204, 1'b0, 2'd0, 16'h0, "R4 live after clear");
        chk("R4 live untouched by clear", reg_rdata, 16'h3284);
        cyc(15'h0000, 1'b1, 2'd2, 16'h0080, "R2 clear bit7");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R2 after clear");
        chk("R2 bit7 cleared", reg_rdata, 16'h0000);
        // R3 event wins over clear
        cyc(15'h0100, 1'b1, 2'd2, 16'h0100, "R3 same cycle");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R3 after");
        chk("R3 event wins", reg_rdata, 16'h0100);
        // R5 enable mask
        cyc(15'h0000, 1'b1, 2'd1, 16'hFFFF, "R5 write");
        cyc(15'h0000, 1'b0, 2'd1, 16'h0, "R5 read");
        chk("R5 enable mask", reg_rdata, 16'h5DDF);
        // R6 priority: arbitration lost over transmit-empty
        cyc(15'h0004, 1'b0, 2'd3, 16'h0, "R6 prio read");
        chk("R6 arb over te", reg_rdata, 16'h0008);
        // R9 writes to status/pending ignored, clear reads 0
        cyc(15'h0000, 1'b1, 2'd0, 16'hFFFF, "R9 write status");
        cyc(15'h0000, 1'b1, 2'd3, 16'hFFFF, "R9 write pending");
        cyc(15'h0000, 1'b0, 2'd0, 16'h0, "R9 status unchanged");
        chk("R9 status unchanged", reg_rdata, 16'h0100);
        cyc(15'h0000, 1'b0, 2'd2, 16'h0, "R9 clear reads zero");
        // R6 none, R7 drop
        cyc(15'h0000, 1'b1, 2'd2, 16'hFFFF, "R2 clear all");
        cyc(15'h0000, 1'b0, 2'd3, 16'h0, "R6 none");
        chk("R6 none read", reg_rdata, 16'h0010);
        cyc(15'h0000, 1'b0, 2'd3, 16'h0, "R7 settle");
        chk("R7 irq low", irq, 1'b0);
        // random
        for (int n = 0; n < 3000; n++) begin
            logic [14:0] ev;
            logic [14:0] spk;
            logic        wr;
            logic [1:0]  a;
            logic [15:0] wd;
            string       tg;
            spk = 15'($urandom) & 15'($urandom) & 15'($urandom) & STK;
            ev  = (15'($urandom) & ~STK) | spk;
            wr  = ($urandom % 3) == 0;
            a   = 2'($urandom);
            wd  = 16'($urandom);
            case (a)
                2'd0: tg = "R1 status";
                2'd1: tg = "R5 enable";
                2'd2: tg = "R9 clear read";
                default: tg = "R6 pending read";
            endcase
            cyc(ev, wr, a, wd, tg);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule